// File: doc/BRIEF.md
# Fractional-Step Line Drawing Engine

This block draws a straight line into a packed-pixel frame buffer. Software programs a set of configuration registers and then writes the start bit. These registers hold a word-aligned origin address, the bit offset of the first pixel inside its 32-bit word, the pixel depth, a 12-bit step fraction for each axis, the pixel count minus one, a direction bit per axis, the line pitch in bytes, a 16-bit line pattern, and a foreground and a background colour.

Once started, the engine offers one pixel write per step on a valid/ready memory write port. Each write carries the 32-bit word address, the chosen colour replicated across the word, and byte enables that cover only the current pixel. Each axis keeps a 12-bit fractional accumulator. An axis moves by one pixel whenever its accumulator wraps. On the horizontal axis that means one pixel width, carried into the next or previous word. On the vertical axis it means one pitch. When the last pixel has been accepted, the engine clears its busy bit and, if enabled, sets a sticky interrupt flag.

Register map (4-bit index): 0 control, 1 origin address, 2 start bit offset (bits 4:0), 3 steps (horizontal fraction in bits 11:0, vertical fraction in bits 27:16), 4 count (bits 11:0), 5 pattern (bits 15:0), 6 foreground, 7 background, 8 pitch, 9 interrupt. The control fields are: bit 0 start (reads back as busy), bit 1 interrupt enable, bit 2 horizontal direction, bit 3 vertical direction (0 = increase address), bits 5:4 depth (0 = 8, 1 = 16, 2 or 3 = 32 bits per pixel).

Top module: `line_draw_engine`

## Requirements
- R1: After reset the control register reads 0, the interrupt output is 0 and mem_valid is 0.
- R2: A control write with bit 0 set while idle starts a line of exactly count+1 pixel writes. Control bit 0 reads 1 until the last write is accepted and 0 from the next cycle on.
- R3: Each axis accumulator starts at 0. After every accepted pixel the axis fraction is added to it. Whenever the sum reaches 4095, 4095 is subtracted and that axis moves one pixel. A fraction of 0xFFF therefore moves the axis on every step.
- R4: A horizontal move changes the bit offset by the pixel depth, upward when the horizontal direction bit is 0 and downward when it is 1. An offset that leaves the range 0..31 wraps modulo 32 and moves the word address by +4 or -4.
- R5: A vertical move adds the pitch to the address when the vertical direction bit is 0 and subtracts it when the bit is 1.
- R6: Byte enables are 1, 3 or 15 (for 8, 16 and 32 bits) shifted left by offset bits 4:3. The data is the colour's low 8 bits repeated four times, its low 16 bits repeated twice, or the full colour, according to depth.
- R7: Pixel k (counting from 0) uses the foreground colour when pattern bit k mod 16 is 1 and the background colour when it is 0.
- R8: While mem_valid is high and mem_ready is low, address, data and byte enables hold and the line does not advance.
- R9: When interrupt enable is set, the interrupt flag rises in the cycle after the last write is accepted. It stays set until a write of bit 0 = 1 to register 9. If that write falls in the completing cycle, the set wins.
- R10: While a line is running, writes to registers 0 to 8 are ignored. This includes a new start and any change to colours, pattern or address. Readback after the line shows the values from before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 4 | Register index for write and read |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data for cfg_addr (combinational) |
| mem_valid | output | 1 | Pixel write offered |
| mem_ready | input | 1 | Memory accepts the offered write |
| mem_addr | output | 32 | Word-aligned byte address |
| mem_data | output | 32 | Colour replicated across the word |
| mem_be | output | 4 | Byte enables of the current pixel |
| irq | output | 1 | Sticky completion interrupt |

## Verification
Two events can meet in the same cycle: completion of the line, which sets the interrupt flag, and a software write that clears it. The bench runs a line with ready held high and aligns the clearing write to the exact edge that accepts the final pixel. The flag must still read 1 afterwards, and a later clear on its own must drop it. A second collision is a start or register write that arrives while a line is in flight. The bench issues such writes partway through a line, and the reference model, which was loaded before the line began, must still match every later pixel.

// File: rtl/line_draw_pkg.sv
// Shared widths, register indices and the configuration record of the
// line drawing engine. Assumes a 32-bit word and byte-addressed memory.
package line_draw_pkg;
    parameter int ADDR_W  = 32;
    parameter int FRAC_W  = 12;
    parameter int CNT_W   = 12;
    parameter int PAT_W   = 16;
    parameter int DATA_W  = 32;
    localparam int FRAC_MOD = (1 << FRAC_W) - 1;
    localparam int OFF_W    = $clog2(DATA_W);

    localparam logic [3:0] RG_CTRL  = 4'd0;
    localparam logic [3:0] RG_ORG   = 4'd1;
    localparam logic [3:0] RG_SUBP  = 4'd2;
    localparam logic [3:0] RG_STEP  = 4'd3;
    localparam logic [3:0] RG_COUNT = 4'd4;
    localparam logic [3:0] RG_PAT   = 4'd5;
    localparam logic [3:0] RG_FG    = 4'd6;
    localparam logic [3:0] RG_BG    = 4'd7;
    localparam logic [3:0] RG_PITCH = 4'd8;
    localparam logic [3:0] RG_IRQ   = 4'd9;

    typedef struct packed {
        logic [ADDR_W-1:0] origin;
        logic [OFF_W-1:0]  subpix;
        logic [FRAC_W-1:0] xfrac;
        logic [FRAC_W-1:0] yfrac;
        logic [CNT_W-1:0]  count;
        logic [PAT_W-1:0]  pattern;
        logic [DATA_W-1:0] fg;
        logic [DATA_W-1:0] bg;
        logic [ADDR_W-1:0] pitch;
        logic              irq_en;
        logic              xneg;
        logic              yneg;
        logic [1:0]        depth;
    } line_cfg_t;

    // Pixel width in bits for a depth code (codes 2 and 3 both mean 32).
    function automatic logic [OFF_W:0] depth_bits(input logic [1:0] code);
        case (code)
            2'd0:    return (OFF_W+1)'(8);
            2'd1:    return (OFF_W+1)'(16);
            default: return (OFF_W+1)'(32);
        endcase
    endfunction
endpackage

// File: rtl/line_draw_regs.sv
// Configuration register file, start pulse and sticky interrupt flag.
// Assumes software does not expect writes to take effect while busy.
module line_draw_regs
    import line_draw_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [3:0]        addr,
    input  logic [31:0]       wdata,
    input  logic              busy,
    input  logic              done,
    output line_cfg_t         cfg,
    output logic              go,
    output logic              irq,
    output logic [31:0]       rdata
);
    line_cfg_t cfg_q;
    logic      irq_q;
    logic      wr_ok;

    assign wr_ok = we && !busy;
    assign go    = wr_ok && (addr == RG_CTRL) && wdata[0];
    assign cfg   = cfg_q;
    assign irq   = irq_q;

    // Holds configuration; writes are accepted only while idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else if (wr_ok) begin
            case (addr)
                RG_CTRL: begin
                    cfg_q.irq_en <= wdata[1];
                    cfg_q.xneg   <= wdata[2];
                    cfg_q.yneg   <= wdata[3];
                    cfg_q.depth  <= wdata[5:4];
                end
                RG_ORG:   cfg_q.origin  <= {wdata[ADDR_W-1:2], 2'b00};
                RG_SUBP:  cfg_q.subpix  <= wdata[OFF_W-1:0];
                RG_STEP: begin
                    cfg_q.xfrac <= wdata[FRAC_W-1:0];
                    cfg_q.yfrac <= wdata[16+FRAC_W-1:16];
                end
                RG_COUNT: cfg_q.count   <= wdata[CNT_W-1:0];
                RG_PAT:   cfg_q.pattern <= wdata[PAT_W-1:0];
                RG_FG:    cfg_q.fg      <= wdata;
                RG_BG:    cfg_q.bg      <= wdata;
                RG_PITCH: cfg_q.pitch   <= wdata;
                default:  ;
            endcase
        end
    end

    // Sticky completion flag; a completion beats a same-cycle clear.
    always_ff @(posedge clk) begin
        if (!rst_n)
            irq_q <= 1'b0;
        else if (done && cfg_q.irq_en)
            irq_q <= 1'b1;
        else if (we && addr == RG_IRQ && wdata[0])
            irq_q <= 1'b0;
    end

    // Combinational readback of the selected register.
    always_comb begin
        rdata = '0;
        case (addr)
            RG_CTRL:  rdata = {26'd0, cfg_q.depth, cfg_q.yneg, cfg_q.xneg,
                               cfg_q.irq_en, busy};
            RG_ORG:   rdata = cfg_q.origin;
            RG_SUBP:  rdata = 32'(cfg_q.subpix);
            RG_STEP:  rdata = {4'd0, cfg_q.yfrac, 4'd0, cfg_q.xfrac};
            RG_COUNT: rdata = 32'(cfg_q.count);
            RG_PAT:   rdata = 32'(cfg_q.pattern);
            RG_FG:    rdata = cfg_q.fg;
            RG_BG:    rdata = cfg_q.bg;
            RG_PITCH: rdata = cfg_q.pitch;
            RG_IRQ:   rdata = {31'd0, irq_q};
            default:  rdata = '0;
        endcase
    end
endmodule

// File: rtl/line_draw_stepper.sv
// Walks the line: per-axis modulo-4095 accumulators, word address and
// bit offset, pattern rotation and remaining-pixel count.
// Assumes the start offset is a multiple of the pixel width.
module line_draw_stepper
    import line_draw_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    input  logic              accept,
    input  line_cfg_t         cfg,
    output logic              busy,
    output logic              done,
    output logic [ADDR_W-1:0] word_addr,
    output logic [OFF_W-1:0]  bit_off,
    output logic              pat_bit
);
    logic              busy_q;
    logic [ADDR_W-1:0] addr_q;
    logic [OFF_W-1:0]  off_q;
    logic [FRAC_W-1:0] accx_q, accy_q;
    logic [CNT_W-1:0]  left_q;
    logic [PAT_W-1:0]  pat_q;

    logic [FRAC_W:0]   sumx, sumy;
    logic              movx, movy;
    logic [FRAC_W-1:0] accx_n, accy_n;
    logic [OFF_W:0]    dbits, offt;
    logic [OFF_W-1:0]  off_n;
    logic [ADDR_W-1:0] xdelta, ydelta;

    assign busy      = busy_q;
    assign done      = busy_q && accept && (left_q == '0);
    assign word_addr = addr_q;
    assign bit_off   = off_q;
    assign pat_bit   = pat_q[0];
    assign dbits     = depth_bits(cfg.depth);

    // Fractional accumulators: a wrap at 4095 moves the axis one pixel.
    always_comb begin
        sumx   = {1'b0, accx_q} + {1'b0, cfg.xfrac};
        sumy   = {1'b0, accy_q} + {1'b0, cfg.yfrac};
        movx   = sumx >= (FRAC_W+1)'(FRAC_MOD);
        movy   = sumy >= (FRAC_W+1)'(FRAC_MOD);
        accx_n = movx ? FRAC_W'(sumx - (FRAC_W+1)'(FRAC_MOD)) : sumx[FRAC_W-1:0];
        accy_n = movy ? FRAC_W'(sumy - (FRAC_W+1)'(FRAC_MOD)) : sumy[FRAC_W-1:0];
    end

    // Horizontal move: offset walks by pixel width, wrapping into the next word.
    always_comb begin
        offt   = cfg.xneg ? ({1'b0, off_q} - dbits) : ({1'b0, off_q} + dbits);
        off_n  = off_q;
        xdelta = '0;
        if (movx) begin
            off_n = offt[OFF_W-1:0];
            if (offt[OFF_W])
                xdelta = cfg.xneg ? -ADDR_W'(DATA_W/8) : ADDR_W'(DATA_W/8);
        end
        ydelta = movy ? (cfg.yneg ? -cfg.pitch : cfg.pitch) : '0;
    end

    // Sequencer state: load on start, advance on each accepted pixel.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            addr_q <= '0;
            off_q  <= '0;
            accx_q <= '0;
            accy_q <= '0;
            left_q <= '0;
            pat_q  <= '0;
        end else if (go) begin
            busy_q <= 1'b1;
            addr_q <= cfg.origin;
            off_q  <= cfg.subpix;
            accx_q <= '0;
            accy_q <= '0;
            left_q <= cfg.count;
            pat_q  <= cfg.pattern;
        end else if (busy_q && accept) begin
            if (left_q == '0) begin
                busy_q <= 1'b0;
            end else begin
                addr_q <= addr_q + xdelta + ydelta;
                off_q  <= off_n;
                accx_q <= accx_n;
                accy_q <= accy_n;
                left_q <= left_q - 1'b1;
                pat_q  <= {pat_q[0], pat_q[PAT_W-1:1]};
            end
        end
    end
endmodule

// File: rtl/line_draw_pixfmt.sv
// Builds the write data and byte enables of one pixel from depth,
// bit offset and colour choice. Purely combinational.
module line_draw_pixfmt
    import line_draw_pkg::*;
(
    input  logic [1:0]        depth,
    input  logic [OFF_W-1:0]  bit_off,
    input  logic              use_fg,
    input  logic [DATA_W-1:0] fg,
    input  logic [DATA_W-1:0] bg,
    output logic [DATA_W-1:0] data,
    output logic [DATA_W/8-1:0] be
);
    localparam int NB = DATA_W / 8;
    logic [DATA_W-1:0] colour;
    logic [NB-1:0]     mask;

    assign colour = use_fg ? fg : bg;

    // Replicate the pixel across the word and pick its lane mask.
    always_comb begin
        case (depth)
            2'd0: begin
                data = {(DATA_W/8){colour[7:0]}};
                mask = NB'(1);
            end
            2'd1: begin
                data = {(DATA_W/16){colour[15:0]}};
                mask = NB'(3);
            end
            default: begin
                data = colour;
                mask = '1;
            end
        endcase
        be = NB'(mask << bit_off[OFF_W-1:3]);
    end
endmodule

// File: rtl/line_draw_engine.sv
// Top of the line drawing engine: register file, stepper and pixel
// formatter joined to a valid/ready memory write port.
module line_draw_engine
    import line_draw_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cfg_we,
    input  logic [3:0]  cfg_addr,
    input  logic [31:0] cfg_wdata,
    output logic [31:0] cfg_rdata,
    output logic        mem_valid,
    input  logic        mem_ready,
    output logic [31:0] mem_addr,
    output logic [31:0] mem_data,
    output logic [3:0]  mem_be,
    output logic        irq
);
    line_cfg_t        cfg;
    logic             go, busy, done, pat_bit;
    logic [OFF_W-1:0] bit_off;

    line_draw_regs u_regs (
        .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr),
        .wdata(cfg_wdata), .busy(busy), .done(done), .cfg(cfg),
        .go(go), .irq(irq), .rdata(cfg_rdata)
    );

    line_draw_stepper u_step (
        .clk(clk), .rst_n(rst_n), .go(go), .accept(mem_ready),
        .cfg(cfg), .busy(busy), .done(done), .word_addr(mem_addr),
        .bit_off(bit_off), .pat_bit(pat_bit)
    );

    line_draw_pixfmt u_fmt (
        .depth(cfg.depth), .bit_off(bit_off), .use_fg(pat_bit),
        .fg(cfg.fg), .bg(cfg.bg), .data(mem_data), .be(mem_be)
    );

    assign mem_valid = busy;
endmodule

// File: rtl/line_draw_engine_chk.sv
// Protocol and flag checks for the line drawing engine, bound to its top.
module line_draw_engine_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        cfg_we,
    input logic [3:0]  cfg_addr,
    input logic [31:0] cfg_wdata,
    input logic        mem_valid,
    input logic        mem_ready,
    input logic [31:0] mem_addr,
    input logic [31:0] mem_data,
    input logic [3:0]  mem_be,
    input logic        irq
);
    assert_stall_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr)
            && $stable(mem_data) && $stable(mem_be)));

    assert_lane_shape_R6: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid |-> ($countones(mem_be) == 1 || $countones(mem_be) == 2
            || $countones(mem_be) == 4));

    assert_drop_after_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_valid) |-> $past(mem_ready));

    assert_irq_from_accept_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(mem_valid && mem_ready));

    assert_irq_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !(cfg_we && cfg_addr == 4'd9 && cfg_wdata[0])) |=> irq);
endmodule

bind line_draw_engine line_draw_engine_chk u_chk (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .mem_valid(mem_valid), .mem_ready(mem_ready),
    .mem_addr(mem_addr), .mem_data(mem_data), .mem_be(mem_be), .irq(irq)
);

// File: tb/line_draw_engine_tb.sv
// Reference-model bench: expected pixel k is computed in closed form
// (carry count = floor(k*frac/4095)) and compared on every clock.
module line_draw_engine_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [3:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        mem_valid, mem_ready, irq;
    logic [31:0] mem_addr, mem_data;
    logic [3:0]  mem_be;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    int rmode = 0;
    bit armed = 1'b0;
    int exp_k = 0;
    int exp_n = 0;

    // model of the programmed line
    longint m_org;
    int m_off, m_xf, m_yf, m_dep, m_pitch, m_xneg, m_yneg, m_dcode;
    logic [15:0] m_pat;
    logic [31:0] m_fg, m_bg;

    always #5 clk = ~clk;

    line_draw_engine u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .mem_valid(mem_valid),
        .mem_ready(mem_ready), .mem_addr(mem_addr), .mem_data(mem_data),
        .mem_be(mem_be), .irq(irq)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic expect_pix(input int k, output logic [31:0] a,
                              output logic [3:0] be, output logic [31:0] d);
        longint xs, ys, bp;
        int off;
        logic [31:0] c;
        xs = (longint'(k) * m_xf) / 4095;
        ys = (longint'(k) * m_yf) / 4095;
        bp = m_org * 8 + m_off + (m_xneg != 0 ? -xs : xs) * m_dep
           + (m_yneg != 0 ? -ys : ys) * m_pitch * 8;
        a = 32'((bp / 32) * 4);
        off = int'(bp % 32);
        c = m_pat[k % 16] ? m_fg : m_bg;
        if (m_dep == 8) begin
            be = 4'(1 << (off / 8)); d = {4{c[7:0]}};
        end else if (m_dep == 16) begin
            be = 4'(3 << (off / 8)); d = {2{c[15:0]}};
        end else begin
            be = 4'hF; d = c;
        end
    endtask

    // Per-clock comparison against the model, away from the active edge.
    always @(negedge clk) begin
        logic [31:0] ea, ed;
        logic [3:0]  eb;
        cyc++;
        case (rmode)
            1: mem_ready = ((cyc * 7) % 5) != 0;
            2: mem_ready = (cyc % 8) >= 3;
            default: mem_ready = 1'b1;
        endcase
        if (armed) begin
            if (exp_k < exp_n) begin
                expect_pix(exp_k, ea, eb, ed);
                check(mem_valid == 1'b1, "R2 valid during line", mem_valid, 1);
                check(mem_addr == ea, "R3/R4/R5 address", mem_addr, ea);
                check(mem_be == eb, "R6 byte enables", mem_be, eb);
                check(mem_data == ed, "R6/R7 data", mem_data, ed);
                if (mem_valid && mem_ready) exp_k++;
            end else begin
                check(mem_valid == 1'b0, "R2 no extra write", mem_valid, 0);
                armed = 1'b0;
            end
        end
    end

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        #1;
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        #1;
        cfg_we = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        #1;
        cfg_addr = a;
        #1;
        d = cfg_rdata;
    endtask

    task automatic setup(input longint org, input int off, input int xf, input int yf,
                         input int cnt, input int dcode, input int xneg, input int yneg,
                         input int pitch, input logic [15:0] pat,
                         input logic [31:0] fg, input logic [31:0] bg);
        m_org = org; m_off = off; m_xf = xf; m_yf = yf; m_dcode = dcode;
        m_dep = (dcode == 0) ? 8 : (dcode == 1) ? 16 : 32;
        m_xneg = xneg; m_yneg = yneg; m_pitch = pitch; m_pat = pat;
        m_fg = fg; m_bg = bg; exp_n = cnt + 1; exp_k = 0;
        wr(4'd1, 32'(org));
        wr(4'd2, 32'(off));
        wr(4'd3, {4'd0, 12'(yf), 4'd0, 12'(xf)});
        wr(4'd4, 32'(cnt));
        wr(4'd5, {16'd0, pat});
        wr(4'd6, fg);
        wr(4'd7, bg);
        wr(4'd8, 32'(pitch));
    endtask

    task automatic start(input bit ien);
        @(negedge clk);
        #1;
        cfg_we = 1'b1; cfg_addr = 4'd0;
        cfg_wdata = {26'd0, 2'(m_dcode), 1'(m_yneg), 1'(m_xneg), ien, 1'b1};
        @(posedge clk);
        #1;
        armed = 1'b1;
        @(negedge clk);
        #1;
        cfg_we = 1'b0;
    endtask

    task automatic wait_line();
        int n = 0;
        while (armed && n < 20000) begin
            @(posedge clk);
            n++;
        end
        check(!armed, "R2 line completes (watchdog)", armed, 0);
        armed = 1'b0;
    endtask

    initial begin
        logic [31:0] r;
        mem_ready = 1'b1;
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
        // R1: reset state
        rd(4'd0, r);
        check(r == 0, "R1 control after reset", r, 0);
        check(irq == 0, "R1 irq after reset", irq, 0);
        check(mem_valid == 0, "R1 valid after reset", mem_valid, 0);

        // R3 R4 R5 R6 R7 R8 R9: 16 bpp, x-major, irregular ready
        rmode = 1;
        setup(64'h0010_0000, 16, 12'hFFF, 12'h49C, 80, 1, 0, 0, 640,
              16'hA5C3, 32'h1234_BEEF, 32'h0000_7E57);
        start(1'b1);
        rd(4'd0, r);
        check(r[0] == 1'b1, "R2 busy reads 1", r[0], 1);
        wait_line();
        check(exp_k == exp_n, "R2 pixel count", exp_k, exp_n);
        rd(4'd0, r);
        check(r[0] == 1'b0, "R2 busy cleared", r[0], 0);
        check(irq == 1'b1, "R9 irq set on completion", irq, 1);
        wr(4'd9, 32'd1);
        check(irq == 1'b0, "R9 irq cleared by write", irq, 0);

        // R4 R5: 8 bpp, both axes decreasing, y-major, long stalls (R8)
        rmode = 2;
        setup(64'h0020_0000, 24, 12'h300, 12'hFFF, 20, 0, 1, 1, 320,
              16'h0F0F, 32'hAABB_CC11, 32'h0000_0022);
        start(1'b0);
        wait_line();
        check(exp_k == exp_n, "R2 pixel count 8bpp", exp_k, exp_n);
        check(irq == 1'b0, "R9 no irq when disabled", irq, 0);

        // R2 R6: single pixel at 32 bpp, background colour
        rmode = 0;
        setup(64'h0000_4000, 0, 12'hFFF, 12'h000, 0, 2, 0, 0, 256,
              16'h0000, 32'hFFFF_FFFF, 32'hCAFE_F00D);
        start(1'b0);
        wait_line();
        check(exp_k == 1, "R2 single pixel", exp_k, 1);

        // R10: writes during a line are ignored
        rmode = 2;
        setup(64'h0030_0000, 8, 12'h7FF, 12'hFFF, 30, 0, 0, 1, 128,
              16'h1357, 32'h0000_0044, 32'h0000_0055);
        start(1'b0);
        repeat (4) @(posedge clk);
        wr(4'd5, 32'h0000_FFFF);
        wr(4'd6, 32'h0000_0099);
        wr(4'd1, 32'h0000_0100);
        wr(4'd0, 32'h0000_0001);
        wait_line();
        check(exp_k == exp_n, "R10 restart ignored", exp_k, exp_n);
        rd(4'd5, r);
        check(r == 32'h1357, "R10 pattern unchanged", r, 32'h1357);
        rd(4'd1, r);
        check(r == 32'h0030_0000, "R10 origin unchanged", r, 32'h0030_0000);

        // R9: clear write in the completing cycle loses to the set
        rmode = 0;
        setup(64'h0040_0000, 0, 12'hFFF, 12'h800, 5, 1, 0, 0, 64,
              16'hFFFF, 32'h0000_00A1, 32'h0000_00B2);
        start(1'b1);
        while (exp_k != exp_n - 1) @(posedge clk);
        @(negedge clk);
        #1;
        cfg_we = 1'b1; cfg_addr = 4'd9; cfg_wdata = 32'd1;
        @(negedge clk);
        #1;
        cfg_we = 1'b0;
        check(irq == 1'b1, "R9 set wins over same-cycle clear", irq, 1);
        wait_line();
        wr(4'd9, 32'd1);
        check(irq == 1'b0, "R9 later clear", irq, 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #1000000;
        total++;
        bad++;
        $display("FAIL R2 watchdog expired actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule